// File: doc/BRIEF.md
# Time-Compressed Sample Display Controller

This block turns a slow stream of 8-bit converter samples into a steady, flicker-free trace on an X/Y display. Each sample tick reads one value from the converter and writes it into a 256-word circular history buffer. A separate replay loop walks the whole buffer once per sweep, many times faster than samples arrive. On every display-point enable it drives an X position and the stored sample for that position to two DAC write ports. For example, with a tick every 7.8 ms and a point every 30.5 µs, the buffer holds about two seconds of trace and the screen refreshes at about 128 Hz.

The X timebase runs in both directions: a left-to-right sweep and then a right-to-left sweep. No retrace blanking or intensity control is needed. The read address is chosen so that X position `x` always shows buffer word `x` in either direction, and the return sweep redraws the same samples in reverse. A freeze input blocks capture while replay continues, so the trace holds still. Capture and replay have independent pointers and never stall each other.

Capture states are `CAP_IDLE` (waiting) and `CAP_READ` (converter read strobe high, buffer write at the end of the cycle).
- Transition `CAP_IDLE -> CAP_READ` happens on a tick when freeze is low.
- Transition `CAP_READ -> CAP_READ` happens on a back-to-back unfrozen tick.
- Otherwise the FSM returns to `CAP_IDLE`.

Replay states are `SWP_UP` (X rising, read address post-incremented) and `SWP_DOWN` (X falling, read address pre-decremented).
- Transition `SWP_UP -> SWP_DOWN` happens on the point drawn at X=255.
- Transition `SWP_DOWN -> SWP_UP` happens on the point drawn at X=0.

Top module: `tcdisp_top`

## Requirements
- R1: After reset `adc_rd_o`, `x_wr_o` and `y_wr_o` are low, the first point is drawn at X=0 going upward, and every buffer word reads as mid-scale 0x80.
- R2: A `tick_i` pulse with `freeze_i` low raises `adc_rd_o` for exactly the next cycle. The `adc_data_i` value present in that cycle is stored at the write pointer, and the write pointer then advances by one.
- R3: A `tick_i` pulse with `freeze_i` high produces no `adc_rd_o` pulse and leaves the buffer and the write pointer unchanged.
- R4: In the upward sweep each point's X is one more than the previous point's X, from 0 up to 255.
- R5: The point after X=255 is drawn again at X=255 and X then falls by one per point to 0. The point after X=0 is drawn again at X=0 and the upward sweep restarts.
- R6: The Y value of every point equals the buffer word whose address equals that point's X, in both sweep directions.
- R7: A `pt_en_i` pulse raises `x_wr_o` and `y_wr_o` together for exactly the next cycle, with `x_o` and `y_o` valid in that cycle. Without `pt_en_i` neither strobe rises.
- R8: When a sample write and a point read address the same word at the same clock edge, the point shows the value held before the write.
- R9: The write pointer wraps from 255 to 0, so the 257th captured sample overwrites word 0.
- R10: Captures do not disturb the replay position: the X sequence continues unchanged across any number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle sample request, synchronous to clk |
| freeze_i | input | 1 | High blocks sample capture |
| adc_data_i | input | 8 | Converter sample value |
| adc_rd_o | output | 1 | Converter read strobe, one cycle per capture |
| pt_en_i | input | 1 | Single-cycle request to draw the next display point |
| x_o | output | 8 | X DAC value |
| x_wr_o | output | 1 | X DAC write strobe |
| y_o | output | 8 | Y DAC value |
| y_wr_o | output | 1 | Y DAC write strobe |

## Verification
`adc_rd_o` rises in the cycle after the tick. The buffer word changes at the clock edge that ends that cycle, so the new value is visible to any point requested after that edge. A point's `x_o`, `y_o` and strobes appear in the cycle after `pt_en_i` and last for that one cycle. The bench drives inputs on the falling edge and samples one falling edge after each request, which is exactly the cycle in which these results are due. The collision case is built by placing `pt_en_i` in the `CAP_READ` cycle, so that read and write meet at the same edge.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    typedef enum logic {
        CAP_IDLE,
        CAP_READ
    } cap_state_e;

    typedef enum logic {
        SWP_UP,
        SWP_DOWN
    } swp_state_e;

endpackage

// File: rtl/tcd_capture.sv
module tcd_capture
    import tcd_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          freeze_i,
    input  logic [DW-1:0] adc_data_i,
    output logic          adc_rd_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    cap_state_e    state_q, state_d;
    logic [AW-1:0] wptr_q;
    logic          take;

    assign take = tick_i && !freeze_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (take) state_d = CAP_READ;
            CAP_READ: state_d = take ? CAP_READ : CAP_IDLE;
            default:  state_d = CAP_IDLE;
        endcase
    end

    // state register and write pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            wptr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CAP_READ) wptr_q <= wptr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        adc_rd_o  = 1'b0;
        wr_en_o   = 1'b0;
        unique case (state_q)
            CAP_IDLE: ;
            CAP_READ: begin
                adc_rd_o = 1'b1;
                wr_en_o  = 1'b1;
            end
            default: ;
        endcase
        wr_addr_o = wptr_q;
        wr_data_o = adc_data_i;
    end

endmodule

// File: rtl/tcd_store.sv
module tcd_store #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    localparam int            DEPTH = 1 << AW;
    localparam logic [DW-1:0] MID   = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= MID;
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    // asynchronous read: a write at the same edge is seen only afterwards
    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/tcd_replay.sv
module tcd_replay
    import tcd_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pt_en_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] x_o,
    output logic          x_wr_o,
    output logic [DW-1:0] y_o,
    output logic          y_wr_o
);

    localparam logic [AW-1:0] X_TOP = '1;
    localparam logic [AW-1:0] X_BOT = '0;

    swp_state_e    state_q, state_d;
    logic [AW-1:0] xcnt_q, xcnt_d;
    logic [AW-1:0] rptr_q, rptr_d;

    // read address: post-increment going up, pre-decrement going down
    assign rd_addr_o = (state_q == SWP_DOWN) ? rptr_q - 1'b1 : rptr_q;

    always_comb begin
        state_d = state_q;
        xcnt_d  = xcnt_q;
        rptr_d  = rptr_q;
        if (pt_en_i) begin
            unique case (state_q)
                SWP_UP: begin
                    rptr_d = rptr_q + 1'b1;
                    if (xcnt_q == X_TOP) state_d = SWP_DOWN;
                    else                 xcnt_d  = xcnt_q + 1'b1;
                end
                SWP_DOWN: begin
                    rptr_d = rd_addr_o;
                    if (xcnt_q == X_BOT) state_d = SWP_UP;
                    else                 xcnt_d  = xcnt_q - 1'b1;
                end
                default: state_d = SWP_UP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SWP_UP;
            xcnt_q  <= X_BOT;
            rptr_q  <= '0;
        end else begin
            state_q <= state_d;
            xcnt_q  <= xcnt_d;
            rptr_q  <= rptr_d;
        end
    end

    // registered DAC outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_o    <= '0;
            y_o    <= '0;
            x_wr_o <= 1'b0;
            y_wr_o <= 1'b0;
        end else begin
            x_wr_o <= pt_en_i;
            y_wr_o <= pt_en_i;
            if (pt_en_i) begin
                x_o <= xcnt_q;
                y_o <= rd_data_i;
            end
        end
    end

endmodule

// File: rtl/tcdisp_top.sv
module tcdisp_top #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              freeze_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_rd_o,
    input  logic              pt_en_i,
    output logic [ADDR_W-1:0] x_o,
    output logic              x_wr_o,
    output logic [DATA_W-1:0] y_o,
    output logic              y_wr_o
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    tcd_capture #(.DW(DATA_W), .AW(ADDR_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .freeze_i   (freeze_i),
        .adc_data_i (adc_data_i),
        .adc_rd_o   (adc_rd_o),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    tcd_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    tcd_replay #(.DW(DATA_W), .AW(ADDR_W)) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .pt_en_i    (pt_en_i),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .x_o        (x_o),
        .x_wr_o     (x_wr_o),
        .y_o        (y_o),
        .y_wr_o     (y_wr_o)
    );

endmodule

// File: rtl/tcd_chk.sv
module tcd_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          freeze_i,
    input logic          adc_rd_o,
    input logic          pt_en_i,
    input logic [AW-1:0] x_o,
    input logic          x_wr_o,
    input logic          y_wr_o,
    input logic [AW-1:0] wptr
);

    logic [AW-1:0] last_x;
    logic          have_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_x    <= '0;
            have_last <= 1'b0;
        end else if (x_wr_o) begin
            last_x    <= x_o;
            have_last <= 1'b1;
        end
    end

    AST_CAPTURE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i) |=> adc_rd_o); // R2

    AST_FREEZE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && freeze_i) |=> !adc_rd_o); // R3

    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_o |=> $stable(wptr)); // R3

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd_o |=> wptr == AW'($past(wptr) + 1'b1)); // R9

    AST_POINT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_en_i |=> (x_wr_o && y_wr_o)); // R7

    AST_NO_SPURIOUS_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        !pt_en_i |=> !(x_wr_o || y_wr_o)); // R7

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (x_wr_o && have_last) |->
            (x_o == AW'(last_x + 1'b1) || x_o == AW'(last_x - 1'b1) || x_o == last_x)); // R4

    AST_TURN_AT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (x_wr_o && have_last && x_o == last_x) |-> (x_o == '0 || x_o == '1)); // R5

endmodule

bind tcdisp_top tcd_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .freeze_i (freeze_i),
    .adc_rd_o (adc_rd_o),
    .pt_en_i  (pt_en_i),
    .x_o      (x_o),
    .x_wr_o   (x_wr_o),
    .y_wr_o   (y_wr_o),
    .wptr     (wr_addr)
);

// File: tb/sim_tcdisp_top.sv
module sim_tcdisp_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i;
    logic       freeze_i;
    logic [7:0] adc_data_i;
    logic       adc_rd_o;
    logic       pt_en_i;
    logic [7:0] x_o;
    logic       x_wr_o;
    logic [7:0] y_o;
    logic       y_wr_o;

    always #2 clk = ~clk;   // 250 MHz

    tcdisp_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
        .adc_data_i(adc_data_i), .adc_rd_o(adc_rd_o), .pt_en_i(pt_en_i),
        .x_o(x_o), .x_wr_o(x_wr_o), .y_o(y_o), .y_wr_o(y_wr_o)
    );

    int checks = 0;
    int fails  = 0;

    // model built from the requirements
    logic [7:0] mem_m [256];
    logic [7:0] wptr_m;
    logic [7:0] xm;
    logic       down_m;
    logic [7:0] last_x, last_y;

    // stimulus table: {freeze, data, expected read strobe}
    localparam logic [9:0] VEC [8] = '{
        {1'b0, 8'h11, 1'b1},
        {1'b0, 8'hF0, 1'b1},
        {1'b1, 8'h33, 1'b0},
        {1'b0, 8'h00, 1'b1},
        {1'b1, 8'hFF, 1'b0},
        {1'b1, 8'h44, 1'b0},
        {1'b0, 8'hFF, 1'b1},
        {1'b0, 8'h7E, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // call at a falling edge; returns at a falling edge
    task automatic do_tick(input logic frz, input logic [7:0] d, input logic exp_rd);
        tick_i = 1'b1; freeze_i = frz; adc_data_i = d;
        @(negedge clk);
        tick_i = 1'b0;
        check(adc_rd_o == exp_rd, frz ? "R3 read strobe" : "R2 read strobe",
              int'(adc_rd_o), int'(exp_rd));
        if (exp_rd) begin
            mem_m[wptr_m] = d;
            wptr_m = wptr_m + 8'd1;
        end
        @(negedge clk);
        check(adc_rd_o == 1'b0, "R2 strobe one cycle", int'(adc_rd_o), 0);
        freeze_i = 1'b0;
    endtask

    task automatic advance_model();
        if (!down_m) begin
            if (xm == 8'hFF) down_m = 1'b1; else xm = xm + 8'd1;
        end else begin
            if (xm == 8'h00) down_m = 1'b0; else xm = xm - 8'd1;
        end
    endtask

    task automatic do_point();
        pt_en_i = 1'b1;
        @(negedge clk);
        pt_en_i = 1'b0;
        check(x_wr_o && y_wr_o, "R7 strobes", int'({x_wr_o, y_wr_o}), 3);
        check(x_o == xm, down_m ? "R5 x down" : "R4 x up", int'(x_o), int'(xm));
        check(y_o == mem_m[xm], "R6 y value", int'(y_o), int'(mem_m[xm]));
        last_x = x_o; last_y = y_o;
        advance_model();
        @(negedge clk);
        check(!x_wr_o && !y_wr_o, "R7 idle strobes", int'({x_wr_o, y_wr_o}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] xs;
        rst_n = 1'b0; tick_i = 1'b0; freeze_i = 1'b0; adc_data_i = 8'h00; pt_en_i = 1'b0;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h80;
        wptr_m = 8'd0; xm = 8'd0; down_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!adc_rd_o && !x_wr_o && !y_wr_o, "R1 outputs idle after reset",
              int'({adc_rd_o, x_wr_o, y_wr_o}), 0);

        // R8: write to word 0 and point at X=0 meet at the same edge
        tick_i = 1'b1; adc_data_i = 8'h5A;
        @(negedge clk);
        tick_i = 1'b0; pt_en_i = 1'b1;
        check(adc_rd_o == 1'b1, "R2 read strobe", int'(adc_rd_o), 1);
        @(negedge clk);
        pt_en_i = 1'b0;
        check(x_o == 8'h00, "R1 first point at x=0", int'(x_o), 0);
        check(y_o == 8'h80, "R8 old value on collision", int'(y_o), 8'h80);
        mem_m[0] = 8'h5A; wptr_m = 8'd1; advance_model();
        @(negedge clk);

        // R1: untouched word reads mid-scale
        while (xm != 8'd200) do_point();
        do_point();
        check(last_y == 8'h80, "R1 mid-scale contents", int'(last_y), 8'h80);

        // table walk; R10: replay position unaffected by captures
        xs = xm;
        for (int v = 0; v < 8; v++) do_tick(VEC[v][9], VEC[v][8:1], VEC[v][0]);
        do_point();
        check(last_x == xs, "R10 replay position kept", int'(last_x), int'(xs));

        // full up and down sweep, R3 frozen values absent, R5 turnarounds
        for (int p = 0; p < 512; p++) do_point();

        // R9: wrap the write pointer and overwrite word 0
        while (wptr_m != 8'd0) do_tick(1'b0, wptr_m ^ 8'hA5, 1'b1);
        do_tick(1'b0, 8'hC3, 1'b1);
        while (!(xm == 8'd0 && !down_m)) do_point();
        do_point();
        check(last_y == 8'hC3, "R9 word 0 overwritten after wrap", int'(last_y), 8'hC3);

        // freeze while drawing: full sweep shows unchanged buffer (R3)
        do_tick(1'b1, 8'hEE, 1'b0);
        for (int p = 0; p < 512; p++) do_point();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule